// File: doc/BRIEF.md
# Audio Packet Transmit Controller

This block turns a stream of 8-bit unsigned audio samples into addressed packets for a shared serial medium. A clock divider paces sample requests at a rate chosen by two mode bits of a configuration switch word. On each request it takes the byte presented by the converter and stores it in an internal FIFO. When the FIFO holds enough samples for one payload, the block waits for the medium to be idle. It then sends a header byte that carries the destination and source station numbers, followed by a fixed number of sample bytes. Bytes go out one at a time over a valid/ready handshake to a byte-wide UART transmitter.

The block is reset synchronously while both push buttons are held. Once a packet has started, the busy flag of the medium is no longer consulted until the last payload byte has been accepted. A sample that arrives while the FIFO is full is discarded, and a sticky overflow flag records the loss until the next reset.

Top module: `audio_pkt_tx`

## Requirements
- R1: While btnA and btnB are both 1 at a clock edge the block resets: afterwards txValid=0, sampleReq=0, overflow=0 and the FIFO is empty. Pressing only one button has no effect on any state, including overflow.
- R2: With cfgSw[7:6]=00, sampleReq pulses for one cycle every CLK_HZ/BASE_RATE_HZ clock cycles.
- R3: With cfgSw[7:6]=01, sampleReq pulses every (CLK_HZ/BASE_RATE_HZ)/2 clock cycles.
- R4: With cfgSw[7:6]=10 or 11, sampleReq stays 0 and no sample is stored.
- R5: adcData is captured at each clock edge where sampleReq=1, and the payload bytes leave in the order they were captured.
- R6: The first byte of each packet is {2'b00, dest, src}, with dest = cfgSw[5:3] and src = cfgSw[2:0] taken in the cycle in which the packet starts. Later switch changes do not alter that header.
- R7: A packet starts (txValid rises with the header) only if, in the preceding cycle, mediumBusy was 0 and the FIFO held at least PAYLOAD_LEN samples.
- R8: After the header, exactly PAYLOAD_LEN payload bytes follow with txValid held high, whatever mediumBusy does.
- R9: While txValid=1 and txReady=0, txValid stays 1 and txData stays unchanged in the next cycle.
- R10: A sample request that finds the FIFO full (FIFO_DEPTH entries) is dropped, and overflow goes to 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| btnA | input | 1 | Push button A; reset when held together with btnB |
| btnB | input | 1 | Push button B; reset when held together with btnA |
| cfgSw | input | 8 | Switches: [7:6] rate mode, [5:3] destination, [2:0] source |
| adcData | input | 8 | Unsigned sample byte from the converter |
| sampleReq | output | 1 | One-cycle request; adcData is stored in this cycle |
| mediumBusy | input | 1 | 1 while the shared medium is in use |
| txReady | input | 1 | UART transmitter accepts txData when high with txValid |
| txData | output | 8 | Packet byte offered to the UART |
| txValid | output | 1 | txData holds a valid byte |
| overflow | output | 1 | Sticky flag: a sample was dropped on a full FIFO |

## Verification
The bench builds the block with CLK_HZ=40000, which gives a sample period of 20 cycles in base mode and 10 cycles in high-rate mode. It also uses PAYLOAD_LEN=4 and FIFO_DEPTH=8. These small values let the run cover many packets, a full FIFO with dropped samples, and mode changes within a few thousand cycles. Holding the medium busy for a short time fills the FIFO. Raising the busy flag right after a header handshake checks that the packet still runs to its end.

// File: rtl/audio_pkt_pkg.sv
package audio_pkt_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_HDR  = 2'd1,
    S_PAY  = 2'd2
  } txState_t;

  typedef struct packed {
    logic latchHdr;
    logic sendHdr;
    logic pop;
  } ctrlStrobe_t;
endpackage

// File: rtl/audio_pkt_datapath.sv
module audio_pkt_datapath
  import audio_pkt_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int BASE_RATE_HZ = 2000,
  parameter int FIFO_DEPTH   = 32,
  parameter int PAYLOAD_LEN  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  cfgSw,
  input  logic [7:0]  adcData,
  input  ctrlStrobe_t ctl,
  output logic        sampleReq,
  output logic        pktReady,
  output logic [7:0]  txData,
  output logic        overflow
);
  localparam int DIV_BASE = CLK_HZ / BASE_RATE_HZ;
  localparam int DIV_HI   = DIV_BASE / 2;
  localparam int CW       = $clog2(DIV_BASE);
  localparam int AW       = $clog2(FIFO_DEPTH);

  // rate pacing
  logic [CW-1:0] divCnt;
  logic [CW-1:0] termCnt;
  logic          modeOk;

  always_comb begin
    modeOk  = ~cfgSw[7];
    termCnt = cfgSw[6] ? CW'(DIV_HI - 1) : CW'(DIV_BASE - 1);
  end

  assign sampleReq = modeOk && (divCnt >= termCnt);

  always_ff @(posedge clk) begin
    if (rst || !modeOk || sampleReq) divCnt <= '0;
    else                             divCnt <= divCnt + CW'(1);
  end

  // sample FIFO
  logic [7:0]  mem [FIFO_DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   count;
  logic          full, push;

  assign full     = (count == (AW+1)'(FIFO_DEPTH));
  assign push     = sampleReq && !full;
  assign pktReady = (count >= (AW+1)'(PAYLOAD_LEN));

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= adcData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push)    wrPtr <= wrPtr + AW'(1);
      if (ctl.pop) rdPtr <= rdPtr + AW'(1);
      case ({push, ctl.pop})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
      if (sampleReq && full) overflow <= 1'b1;
    end
  end

  // header snapshot and byte select
  logic [7:0] hdrReg;

  always_ff @(posedge clk) begin
    if (rst)               hdrReg <= '0;
    else if (ctl.latchHdr) hdrReg <= {2'b00, cfgSw[5:3], cfgSw[2:0]};
  end

  assign txData = ctl.sendHdr ? hdrReg : mem[rdPtr];

  // R10: once set, the loss flag holds until reset
  a_r10_sticky_ovf: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R8: payload reads never underrun the FIFO
  a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    ctl.pop |-> count != '0);

  // R5: an accepted sample with no read grows the fill by one
  a_r5_count_track: assert property (@(posedge clk) disable iff (rst)
    (push && !ctl.pop) |=> count == $past(count) + (AW+1)'(1));

  // R2: requests are single-cycle pulses
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    sampleReq |=> !sampleReq);
endmodule

// File: rtl/audio_pkt_ctrl.sv
module audio_pkt_ctrl
  import audio_pkt_pkg::*;
#(
  parameter int PAYLOAD_LEN = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pktReady,
  input  logic        mediumBusy,
  input  logic        txReady,
  output logic        txValid,
  output ctrlStrobe_t ctl
);
  localparam int BW = $clog2(PAYLOAD_LEN + 1);

  txState_t      state, stateNext;
  logic [BW-1:0] byteCnt, byteCntNext;

  always_comb begin
    stateNext   = state;
    byteCntNext = byteCnt;
    ctl         = '0;
    txValid     = 1'b0;
    case (state)
      S_IDLE: begin
        if (pktReady && !mediumBusy) begin
          ctl.latchHdr = 1'b1;
          stateNext    = S_HDR;
        end
      end
      S_HDR: begin
        txValid     = 1'b1;
        ctl.sendHdr = 1'b1;
        if (txReady) begin
          byteCntNext = '0;
          stateNext   = S_PAY;
        end
      end
      S_PAY: begin
        txValid = 1'b1;
        if (txReady) begin
          ctl.pop = 1'b1;
          if (byteCnt == BW'(PAYLOAD_LEN - 1)) stateNext = S_IDLE;
          else                                 byteCntNext = byteCnt + BW'(1);
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      byteCnt <= '0;
    end else begin
      state   <= stateNext;
      byteCnt <= byteCntNext;
    end
  end

  // R7: a packet begins only on an idle medium with a full payload stored
  a_r7_start_gate: assert property (@(posedge clk) disable iff (rst)
    (state == S_HDR && $past(state) == S_IDLE) |-> $past(!mediumBusy && pktReady));

  // R8: payload phase continues until its last byte is taken
  a_r8_no_abort: assert property (@(posedge clk) disable iff (rst)
    (state == S_PAY && !txReady) |=> state == S_PAY);
endmodule

// File: rtl/audio_pkt_tx.sv
module audio_pkt_tx
  import audio_pkt_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int BASE_RATE_HZ = 2000,
  parameter int FIFO_DEPTH   = 32,
  parameter int PAYLOAD_LEN  = 16
) (
  input  logic       clk,
  input  logic       btnA,
  input  logic       btnB,
  input  logic [7:0] cfgSw,
  input  logic [7:0] adcData,
  output logic       sampleReq,
  input  logic       mediumBusy,
  input  logic       txReady,
  output logic [7:0] txData,
  output logic       txValid,
  output logic       overflow
);
  logic        rst;
  logic        pktReady;
  ctrlStrobe_t ctl;

  assign rst = btnA & btnB;

  audio_pkt_datapath #(
    .CLK_HZ(CLK_HZ), .BASE_RATE_HZ(BASE_RATE_HZ),
    .FIFO_DEPTH(FIFO_DEPTH), .PAYLOAD_LEN(PAYLOAD_LEN)
  ) u_dp (
    .clk(clk), .rst(rst), .cfgSw(cfgSw), .adcData(adcData), .ctl(ctl),
    .sampleReq(sampleReq), .pktReady(pktReady), .txData(txData),
    .overflow(overflow)
  );

  audio_pkt_ctrl #(.PAYLOAD_LEN(PAYLOAD_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .pktReady(pktReady), .mediumBusy(mediumBusy),
    .txReady(txReady), .txValid(txValid), .ctl(ctl)
  );

  // R9: an offered byte is held until accepted
  a_r9_hold_offer: assert property (@(posedge clk) disable iff (rst)
    (txValid && !txReady) |=> (txValid && $stable(txData)));
endmodule

// File: tb/audio_pkt_tx_tb.sv
module audio_pkt_tx_tb;
  localparam int CLK_HZ = 40000;
  localparam int BASE   = 2000;
  localparam int DEPTH  = 8;
  localparam int PL     = 4;
  localparam int DIV_B  = CLK_HZ / BASE;
  localparam int DIV_H  = DIV_B / 2;

  logic       clk = 1'b0;
  logic       btnA = 1'b1, btnB = 1'b1;
  logic [7:0] cfgSw = 8'h2B;
  logic [7:0] adcData = 8'h10;
  logic       mediumBusy = 1'b0;
  logic       txReady = 1'b0;
  logic       sampleReq, txValid, overflow;
  logic [7:0] txData;

  audio_pkt_tx #(.CLK_HZ(CLK_HZ), .BASE_RATE_HZ(BASE), .FIFO_DEPTH(DEPTH),
                 .PAYLOAD_LEN(PL)) u_dut (
    .clk(clk), .btnA(btnA), .btnB(btnB), .cfgSw(cfgSw), .adcData(adcData),
    .sampleReq(sampleReq), .mediumBusy(mediumBusy), .txReady(txReady),
    .txData(txData), .txValid(txValid), .overflow(overflow)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int cyc = 0;
  bit readyRandom = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  always @(posedge clk) cyc++;

  // stimulus for samples and the UART ready line
  initial begin
    logic [7:0] lfsr = 8'hA5;
    forever begin
      @(posedge clk); #2;
      adcData = adcData + 8'd37;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (readyRandom) txReady = lfsr[0] | lfsr[2];
    end
  end

  // scoreboard model
  logic [7:0] sbq[$];
  bit         ovfModel = 1'b0;
  int         byteIdx = 0;
  int         lastStrobe = -1;
  int         pktDone = 0;
  int         reqCount = 0;
  logic [7:0] expHdr = '0;
  logic       prevValid = 0, prevReady = 0, prevBusy = 0;
  logic [7:0] prevData = '0, prevCfg = '0;

  always @(negedge clk) begin
    if (btnA && btnB) begin
      sbq.delete();
      ovfModel = 1'b0; byteIdx = 0; lastStrobe = -1;
      prevValid = 0; prevReady = 0; prevBusy = 1; prevData = '0; prevCfg = cfgSw;
    end else begin
      bit fullNow;
      fullNow = (sbq.size() >= DEPTH);
      // overflow flag against model (R10)
      if (overflow !== ovfModel) check(1'b0, "R10 overflow", overflow, ovfModel);
      // held offer (R9)
      if (prevValid && !prevReady) begin
        check(txValid === 1'b1, "R9 valid held", txValid, 1);
        check(txData === prevData, "R9 data stable", txData, prevData);
      end
      if (txValid) begin
        if (!prevValid && byteIdx == 0) begin
          check(prevBusy === 1'b0, "R7 medium idle at start", prevBusy, 0);
          check(sbq.size() >= PL, "R7 enough samples", sbq.size(), PL);
          expHdr = {2'b00, prevCfg[5:3], prevCfg[2:0]};
        end
        if (txReady) begin
          if (byteIdx == 0) begin
            check(txData === expHdr, "R6 header", txData, expHdr);
          end else begin
            logic [7:0] e;
            e = sbq.pop_front();
            check(txData === e, "R5 payload order", txData, e);
          end
          if (byteIdx == PL) begin byteIdx = 0; pktDone++; end
          else byteIdx++;
        end
      end else if (byteIdx != 0) begin
        check(1'b0, "R8 gap inside packet", 0, 1);
      end
      // sampling and pacing (R2 R3 R4 R10)
      if (cfgSw[7:6] != prevCfg[7:6]) lastStrobe = -1;
      if (sampleReq) begin
        reqCount++;
        if (cfgSw[7]) check(1'b0, "R4 request in reserved mode", 1, 0);
        if (lastStrobe >= 0) begin
          if (cfgSw[6]) check(cyc - lastStrobe == DIV_H, "R3 period", cyc - lastStrobe, DIV_H);
          else          check(cyc - lastStrobe == DIV_B, "R2 period", cyc - lastStrobe, DIV_B);
        end
        lastStrobe = cyc;
        if (fullNow) ovfModel = 1'b1;
        else         sbq.push_back(adcData);
      end
      prevValid = txValid; prevReady = txReady; prevData = txData;
      prevBusy = mediumBusy; prevCfg = cfgSw;
    end
  end

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", cyc, 60000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c0;
    step(4);
    btnA = 1'b0; btnB = 1'b0;
    step(1);
    @(negedge clk);
    check(txValid === 1'b0, "R1 txValid after reset", txValid, 0);
    check(sampleReq === 1'b0, "R1 sampleReq after reset", sampleReq, 0);
    check(overflow === 1'b0, "R1 overflow after reset", overflow, 0);

    // base rate, dest 5 src 3
    readyRandom = 1'b1;
    cfgSw = {2'b00, 3'd5, 3'd3};
    step(600);
    check(pktDone >= 4, "R2 packets in base mode", pktDone, 4);

    // high rate, dest 2 src 6, header switches changed while a header stalls
    cfgSw = {2'b01, 3'd2, 3'd6};
    c0 = pktDone;
    step(300);
    wait (txValid && byteIdx == 0 && !txReady);
    #1 cfgSw = {2'b01, 3'd7, 3'd1};
    step(300);
    check(pktDone - c0 >= 4, "R3 packets in high-rate mode", pktDone - c0, 4);

    // busy rises right after a header is taken; packet must still finish
    wait (byteIdx == 1);
    step(1);
    mediumBusy = 1'b1;
    c0 = pktDone;
    step(60);
    check(pktDone == c0 + 1, "R8 packet completes under busy", pktDone, c0 + 1);
    step(240);
    check(overflow === 1'b1, "R10 overflow after fill", overflow, 1);
    check(txValid === 1'b0, "R7 no start while busy", txValid, 0);

    // a single button does nothing
    btnA = 1'b1;
    step(5);
    btnA = 1'b0;
    step(1);
    check(overflow === 1'b1, "R1 single button ignored", overflow, 1);

    // release medium and drain
    mediumBusy = 1'b0;
    step(300);

    // reserved modes
    cfgSw = {2'b10, 3'd1, 3'd2};
    step(1);
    c0 = reqCount;
    step(200);
    cfgSw = {2'b11, 3'd1, 3'd2};
    step(200);
    check(reqCount == c0, "R4 no requests in reserved modes", reqCount - c0, 0);

    // full reset clears the sticky flag
    btnA = 1'b1; btnB = 1'b1;
    step(3);
    btnA = 1'b0; btnB = 1'b0;
    step(1);
    @(negedge clk);
    check(overflow === 1'b0, "R1 overflow cleared", overflow, 0);
    check(txValid === 1'b0, "R1 txValid cleared", txValid, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule